// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block is a management-bus master for external Ethernet PHYs. Software sees five 32-bit registers on a simple write/read bus: a mode register, a PHY/register address register, a write-data register, a read-data register and a command register. Software fills in the address and the data, then writes the command register with the start bit and an access code. The block captures the whole request, runs one 64-bit serial frame on MDC/MDIO, and shows busy in the command register until the frame has finished.

A mode bit selects the frame format. Clause 22 frames carry the register number in the frame itself. Clause 45 accesses take two frames, each started by its own command. The first is an address frame that carries the 16-bit register address from the write-data register. The second is a write frame or a read frame. MDC is made from the system clock by a programmable divider. The master changes MDIO on the falling edge of MDC and samples it on the rising edge. It releases the line for the turnaround and data bits of a read.

Top module: `mdio_master`

## Requirements
- R1: After reset the mode register reads 0x000000FF, which is divide-by-256 and Clause 22. The address, write-data, read-data and command registers read 0. MDC is low and `mdio_oe` is low.
- R2: Register offsets are 0x40 mode, 0x44 address, 0x48 write data, 0x4C read data and 0x50 command. Mode bits [7:0] hold the divider N, bit 8 selects Clause 45 and bit 12 is a stored MDC-mode bit. Address bits [12:8] hold the PHY address and bits [4:0] hold the register or device number. Write data uses bits [15:0]. Unlisted bits read 0, and writes to the read-data register are ignored.
- R3: During a frame MDC has a period of N+1 system clocks. An N of 0 behaves like N=1. A frame is exactly 64 MDC periods, so busy stays set for 64*(N+1) cycles.
- R4: A Clause 22 write (mode bit 8 = 0, code 1) sends 32 ones, then 01, 01, the PHY address, the register number, 10 and the 16 write-data bits, each field MSB first.
- R5: A Clause 22 read (code 0) sends 32 ones, 01, 10, the PHY address and the register number, then releases MDIO for the last 18 bits. The 16 bits sampled on the last 16 rising MDC edges appear in the read-data register when busy clears.
- R6: A Clause 45 address frame (mode bit 8 = 1, code 0) sends start 00, opcode 00, the PHY and device numbers, 10 and the write-data register as the 16-bit register address.
- R7: A Clause 45 write (code 1) sends opcode 01 with the write data. A Clause 45 read (code 2) sends opcode 11 and returns data as in R5.
- R8: Writing the command register with bit 8 set starts a frame. Command bit 16 reads 1 from the next cycle until the frame ends. Bits [1:0] read back the code of the last accepted command.
- R9: A start written while busy is set is ignored. The running frame, its length and the stored code are unchanged, and no further frame follows.
- R10: A command without bit 8, Clause 22 codes 2 and 3, and Clause 45 code 3 start nothing: busy stays 0 and MDC does not toggle.
- R11: While idle, MDC is held low and MDIO is not driven.
- R12: While the master drives MDIO, the line changes only when MDC falls, never while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | High when the master drives MDIO |
| mdio_in | input | 1 | Value seen on the shared MDIO line |

## Verification
The assertions assume one register access per cycle. They also assume `mdio_in` reflects the resolved line, with a pull-up when nobody drives it. The stimulus meets both: the bench issues one bus write per cycle and resolves the line itself from the master and from a responder model. The responder drives only after the turnaround bit of a read addressed to its PHY. The responder checks for contention against `mdio_oe`. Random frames use small dividers to keep the run short. Directed cases cover divide-by-256, the N=0 floor, an odd divider, an absent PHY, invalid codes and a start issued mid-frame.

// File: rtl/mdio_master_pkg.sv
// Package: shared constants and the captured request type of the MDIO master.
// Assumes the register field positions below are what software decodes.
package mdio_master_pkg;
    localparam int BUS_AW      = 8;
    localparam int BUS_DW      = 32;
    localparam int DIV_W       = 8;
    localparam int PHY_W       = 5;
    localparam int SEL_W       = 5;
    localparam int WORD_W      = 16;
    localparam int FRAME_BITS  = 64;
    localparam int PRE_BITS    = 32;

    localparam logic [BUS_AW-1:0] OFS_MODE  = 8'h40;
    localparam logic [BUS_AW-1:0] OFS_ADDR  = 8'h44;
    localparam logic [BUS_AW-1:0] OFS_WDATA = 8'h48;
    localparam logic [BUS_AW-1:0] OFS_RDATA = 8'h4C;
    localparam logic [BUS_AW-1:0] OFS_CMD   = 8'h50;

    localparam int POS_C45     = 8;
    localparam int POS_MDCSEL  = 12;
    localparam int POS_PHY     = 8;
    localparam int POS_GO      = 8;
    localparam int POS_BUSY    = 16;

    typedef struct packed {
        logic              c45;
        logic [1:0]        code;
        logic [PHY_W-1:0]  phy;
        logic [SEL_W-1:0]  sel;
        logic [WORD_W-1:0] data;
    } mdio_req_t;
endpackage

// File: rtl/mdio_regs.sv
// Module: register file of the MDIO master.
// Holds mode, address, write data, read data and the last command code.
// Turns a valid command write into a one-cycle start. Assumes one access per cycle.
module mdio_regs
    import mdio_master_pkg::*;
#(
    parameter logic [DIV_W-1:0] RESET_DIV = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              busy,
    input  logic              rd_load,
    input  logic [WORD_W-1:0] rd_value,
    output logic              start,
    output mdio_req_t         req,
    output logic [DIV_W-1:0]  div
);
    logic [DIV_W-1:0]  div_q;
    logic              c45_q;
    logic              mdcsel_q;
    logic [PHY_W-1:0]  phy_q;
    logic [SEL_W-1:0]  sel_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rdata_q;
    logic [1:0]        code_q;
    logic              cmd_hit;
    logic              code_ok;

    // Decode a command write and check its code against the current format.
    always_comb begin
        cmd_hit = bus_wr && (bus_addr == OFS_CMD) && bus_wdata[POS_GO];
        code_ok = c45_q ? (bus_wdata[1:0] != 2'd3) : !bus_wdata[1];
        start   = cmd_hit && code_ok && !busy;
    end

    // Capture configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= RESET_DIV;
            c45_q    <= 1'b0;
            mdcsel_q <= 1'b0;
            phy_q    <= '0;
            sel_q    <= '0;
            wdata_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_MODE: begin
                    div_q    <= bus_wdata[DIV_W-1:0];
                    c45_q    <= bus_wdata[POS_C45];
                    mdcsel_q <= bus_wdata[POS_MDCSEL];
                end
                OFS_ADDR: begin
                    phy_q <= bus_wdata[POS_PHY +: PHY_W];
                    sel_q <= bus_wdata[SEL_W-1:0];
                end
                OFS_WDATA: wdata_q <= bus_wdata[WORD_W-1:0];
                default: ;
            endcase
        end
    end

    // Remember the code of the last accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)     code_q <= '0;
        else if (start) code_q <= bus_wdata[1:0];
    end

    // Load read data when a read frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_load) rdata_q <= rd_value;
    end

    // Read-back multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE: begin
                bus_rdata[DIV_W-1:0]  = div_q;
                bus_rdata[POS_C45]    = c45_q;
                bus_rdata[POS_MDCSEL] = mdcsel_q;
            end
            OFS_ADDR: begin
                bus_rdata[POS_PHY +: PHY_W] = phy_q;
                bus_rdata[SEL_W-1:0]        = sel_q;
            end
            OFS_WDATA: bus_rdata[WORD_W-1:0] = wdata_q;
            OFS_RDATA: bus_rdata[WORD_W-1:0] = rdata_q;
            OFS_CMD: begin
                bus_rdata[POS_BUSY] = busy;
                bus_rdata[1:0]      = code_q;
            end
            default: ;
        endcase
    end

    // Present the request; the code comes straight from the command write.
    always_comb begin
        req      = '{c45: c45_q, code: bus_wdata[1:0], phy: phy_q, sel: sel_q, data: wdata_q};
        div      = div_q;
    end

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && busy) |=> $stable(code_q));
endmodule

// File: rtl/mdio_clkdiv.sv
// Module: MDC generator.
// Counts N+1 system clocks per MDC period (N of 0 treated as 1). The low phase
// comes first. Flags the edges where MDC rises and falls. Stays low while run is 0.
module mdio_clkdiv
    import mdio_master_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] neff;
    logic [DIV_W:0]   low_len;
    logic             mdc_q;

    // Effective divider and the length of the low phase.
    always_comb begin
        neff     = (div == '0) ? DIV_W'(1) : div;
        low_len  = ({1'b0, neff} + 1'b1) >> 1;
        rise_evt = run && ({1'b0, cnt_q} == low_len - 1'b1);
        fall_evt = run && (cnt_q == neff);
    end

    // Phase counter, cleared while idle and at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (fall_evt)  cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // MDC level register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) mdc_q <= 1'b0;
        else if (rise_evt)  mdc_q <= 1'b1;
        else if (fall_evt)  mdc_q <= 1'b0;
    end

    assign mdc = mdc_q;

    assert_mdc_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !mdc);
    assert_rise_from_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |-> !mdc);
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= neff));
endmodule

// File: rtl/mdio_seq.sv
// Module: frame sequencer.
// Latches a 64-bit frame and the divider at start. Shifts one bit out per MDC
// falling edge. Releases MDIO for the read turnaround and data, and samples read
// bits on MDC rising edges. Assumes start only arrives while idle.
module mdio_seq
    import mdio_master_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic [DIV_W-1:0]  div_in,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_in,
    output logic              busy,
    output logic [DIV_W-1:0]  div_run,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              rd_load,
    output logic [WORD_W-1:0] rd_value
);
    localparam int IDX_W    = $clog2(FRAME_BITS);
    localparam int LAST_IDX = FRAME_BITS - 1;
    localparam int TA_IDX   = FRAME_BITS - WORD_W - 2;
    localparam int DAT_IDX  = FRAME_BITS - WORD_W;

    logic [FRAME_BITS-1:0] frame_n;
    logic [FRAME_BITS-1:0] frame_q;
    logic                  rd_n;
    logic                  rd_q;
    logic                  busy_q;
    logic [IDX_W-1:0]      idx_q;
    logic [DIV_W-1:0]      div_q;
    logic [WORD_W-1:0]     sh_q;
    logic [1:0]            st;
    logic [1:0]            op;

    // Assemble the frame for the requested format and access code.
    always_comb begin
        st   = req.c45 ? 2'b00 : 2'b01;
        rd_n = req.c45 ? (req.code == 2'd2) : (req.code == 2'd0);
        if (req.c45) op = (req.code == 2'd2) ? 2'b11 : {1'b0, req.code[0]};
        else         op = req.code[0] ? 2'b01 : 2'b10;
        frame_n = {{PRE_BITS{1'b1}}, st, op, req.phy, req.sel, 2'b10,
                   rd_n ? {WORD_W{1'b0}} : req.data};
    end

    // Frame state: latch at start, advance on each MDC falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            frame_q <= '0;
            rd_q    <= 1'b0;
            idx_q   <= '0;
            div_q   <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            frame_q <= frame_n;
            rd_q    <= rd_n;
            idx_q   <= '0;
            div_q   <= div_in;
        end else if (busy_q && fall_evt) begin
            if (idx_q == IDX_W'(LAST_IDX)) begin
                busy_q <= 1'b0;
            end else begin
                idx_q   <= idx_q + 1'b1;
                frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // Shift in read data on MDC rising edges of the data field.
    always_ff @(posedge clk) begin
        if (!rst_n)                                                  sh_q <= '0;
        else if (busy_q && rd_q && rise_evt && idx_q >= IDX_W'(DAT_IDX)) sh_q <= {sh_q[WORD_W-2:0], mdio_in};
    end

    // Output drive and completion strobe.
    always_comb begin
        mdio_out = frame_q[FRAME_BITS-1];
        mdio_oe  = busy_q && !(rd_q && idx_q >= IDX_W'(TA_IDX));
        rd_load  = busy_q && fall_evt && rd_q && (idx_q == IDX_W'(LAST_IDX));
        rd_value = sh_q;
        busy     = busy_q;
        div_run  = div_q;
    end

    assert_start_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);
    assert_out_changes_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fall_evt) |=> $stable(mdio_out));
    assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fall_evt) |=> busy_q);
    assert_frame_full_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(idx_q) == IDX_W'(LAST_IDX)));
endmodule

// File: rtl/mdio_master.sv
// Module: top of the register-mapped MDIO master.
// Connects the register file, the MDC generator and the frame sequencer.
// Assumes mdio_in carries the resolved, pulled-up MDIO line.
module mdio_master
    import mdio_master_pkg::*;
#(
    parameter logic [7:0] RESET_DIV = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic              start;
    mdio_req_t         req;
    logic [DIV_W-1:0]  div_cfg;
    logic [DIV_W-1:0]  div_run;
    logic              busy;
    logic              rise_evt;
    logic              fall_evt;
    logic              rd_load;
    logic [WORD_W-1:0] rd_value;

    mdio_regs #(.RESET_DIV(RESET_DIV)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .rd_load(rd_load), .rd_value(rd_value), .start(start), .req(req),
        .div(div_cfg)
    );

    mdio_clkdiv u_clkdiv (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div_run), .mdc(mdc),
        .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    mdio_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .req(req), .div_in(div_cfg),
        .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_in(mdio_in),
        .busy(busy), .div_run(div_run), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .rd_load(rd_load), .rd_value(rd_value)
    );
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
// Bench: bus driver, behavioural PHY responder at address 3, and checks.
module mdio_master_bench;
    localparam logic [7:0] A_MODE = 8'h40, A_ADDR = 8'h44, A_WDATA = 8'h48,
                           A_RDATA = 8'h4C, A_CMD = 8'h50;
    localparam logic [4:0] PHY_ID = 5'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_out, mdio_oe, mdio_in;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // responder state
    logic        phy_oe = 1'b0;
    logic        phy_out = 1'b0;
    logic [15:0] c22mem [32];
    logic [15:0] c45mem [16];
    logic [15:0] c45ptr = '0;
    logic [63:0] cap = '0;
    logic [63:0] last_frame = '0;
    logic [15:0] rd_word = '0;
    logic [1:0]  f_st, f_op;
    logic [4:0]  f_phy, f_reg;
    logic        f_hit = 1'b0, f_rd = 1'b0, rd_active = 1'b0;
    int          phy_k = 0;
    int          frames = 0;
    int          rises = 0;
    int          period_err = 0;
    int          exp_period = 256;
    time         last_rise = 0;
    int          contention = 0;
    int          change_high = 0;
    logic        prev_out = 1'b0, prev_oe = 1'b0;

    assign mdio_in = mdio_oe ? mdio_out : (phy_oe ? phy_out : 1'b1);

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // PHY responder: sample on MDC rise, drive read bits after the rise.
    always @(posedge mdc) begin
        rises++;
        if (phy_k != 0 && ($time - last_rise) != time'(exp_period * 20)) period_err++;
        last_rise = $time;
        cap = {cap[62:0], mdio_in};
        if (phy_k == 45) begin
            f_st = cap[13:12]; f_op = cap[11:10]; f_phy = cap[9:5]; f_reg = cap[4:0];
            f_hit = (f_phy == PHY_ID);
            f_rd  = (f_st == 2'b01 && f_op == 2'b10) || (f_st == 2'b00 && f_op == 2'b11);
            rd_active = f_hit && f_rd;
            rd_word = (f_st == 2'b01) ? c22mem[f_reg] : c45mem[c45ptr[3:0]];
        end
        if (phy_k == 46 && rd_active) begin phy_oe = 1'b1; phy_out = 1'b0; end
        if (phy_k >= 47 && phy_k <= 62 && rd_active) phy_out = rd_word[62 - phy_k];
        if (phy_k == 63) begin
            phy_oe = 1'b0; rd_active = 1'b0;
            last_frame = cap; frames++;
            if (f_hit && !f_rd) begin
                if (f_st == 2'b01 && f_op == 2'b01) c22mem[f_reg] = cap[15:0];
                if (f_st == 2'b00 && f_op == 2'b00) c45ptr = cap[15:0];
                if (f_st == 2'b00 && f_op == 2'b01) c45mem[c45ptr[3:0]] = cap[15:0];
            end
        end
        phy_k = (phy_k == 63) ? 0 : phy_k + 1;
    end

    // Line monitors: contention and changes while MDC is high.
    always @(negedge clk) begin
        if (mdio_oe && phy_oe) contention++;
        if (mdio_oe && prev_oe && mdio_out != prev_out && mdc) change_high++;
        prev_out = mdio_out; prev_oe = mdio_oe;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    function automatic logic [63:0] exp_frame(input logic c45, input logic [1:0] code,
            input logic [4:0] phy, input logic [4:0] sel, input logic [15:0] data);
        logic [1:0] st, op;
        st = c45 ? 2'b00 : 2'b01;
        if (c45) op = (code == 2'd2) ? 2'b11 : (code == 2'd1 ? 2'b01 : 2'b00);
        else     op = (code == 2'd1) ? 2'b01 : 2'b10;
        return {32'hFFFF_FFFF, st, op, phy, sel, 2'b10, data};
    endfunction

    function automatic bit is_rd(input logic c45, input logic [1:0] code);
        return c45 ? (code == 2'd2) : (code == 2'd0);
    endfunction

    task automatic set_mode(input logic c45, input logic [7:0] div);
        bus_write(A_MODE, {23'd0, c45, div});
        exp_period = ((div == 8'd0) ? 1 : int'(div)) + 1;
    endtask

    // Launch a command and count the cycles busy reads as set.
    task automatic run_cmd(input logic [1:0] code, output int cyc);
        bus_write(A_CMD, 32'h100 | 32'(code));
        bus_addr = A_CMD; #1;
        cyc = 0;
        while (bus_rdata[16] && cyc < 20000) begin
            cyc++; @(negedge clk); #1;
        end
    endtask

    // One full frame with frame, length, period and data checks.
    task automatic frame_op(input string tag, input logic c45, input logic [1:0] code,
            input logic [4:0] phy, input logic [4:0] sel, input logic [15:0] data,
            output logic [15:0] rdv);
        int cyc, perr0;
        logic [31:0] r;
        logic [63:0] ef;
        perr0 = period_err;
        bus_write(A_ADDR, {19'd0, phy, 3'd0, sel});
        bus_write(A_WDATA, {16'd0, data});
        run_cmd(code, cyc);
        chk({tag, " R3 busy length"}, 64'(cyc), 64'(64 * exp_period));
        chk({tag, " R3 MDC period"}, 64'(period_err - perr0), 64'd0);
        ef = exp_frame(c45, code, phy, sel, data);
        if (is_rd(c45, code)) chk({tag, " header"}, {46'd0, last_frame[63:18]}, {46'd0, ef[63:18]});
        else                  chk({tag, " frame"}, last_frame, ef);
        bus_read(A_RDATA, r);
        rdv = r[15:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [15:0] rv, v;
        int cyc, f0, seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 32; i++) c22mem[i] = 16'(i * 16'h1111);
        for (int i = 0; i < 16; i++) c45mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(A_MODE, r);  chk("R1 mode", 64'(r), 64'h0000_00FF);
        bus_read(A_ADDR, r);  chk("R1 addr", 64'(r), 64'h0);
        bus_read(A_WDATA, r); chk("R1 wdata", 64'(r), 64'h0);
        bus_read(A_RDATA, r); chk("R1 rdata", 64'(r), 64'h0);
        bus_read(A_CMD, r);   chk("R1 cmd", 64'(r), 64'h0);
        chk("R1 R11 idle mdc", 64'(mdc), 64'd0);
        chk("R1 R11 idle oe", 64'(mdio_oe), 64'd0);

        // R2 field layout and read-only read data
        bus_write(A_ADDR, 32'hFFFF_FFFF);  bus_read(A_ADDR, r);  chk("R2 addr fields", 64'(r), 64'h1F1F);
        bus_write(A_WDATA, 32'hFFFF_FFFF); bus_read(A_WDATA, r); chk("R2 wdata field", 64'(r), 64'hFFFF);
        bus_write(A_MODE, 32'hFFFF_FFFF);  bus_read(A_MODE, r);  chk("R2 mode fields", 64'(r), 64'h11FF);
        bus_write(A_RDATA, 32'h1234);      bus_read(A_RDATA, r); chk("R2 rdata read-only", 64'(r), 64'h0);

        // R3 R4 default divide-by-256 Clause 22 write
        set_mode(1'b0, 8'hFF);
        frame_op("R4 c22 write div256", 1'b0, 2'd1, PHY_ID, 5'd5, 16'hA5C3, rv);
        bus_read(A_CMD, r); chk("R8 code readback", 64'(r), 64'h1);
        chk("R11 idle after frame mdc", 64'(mdc), 64'd0);
        chk("R11 idle after frame oe", 64'(mdio_oe), 64'd0);

        // R5 read back, absent PHY reads the pull-up
        set_mode(1'b0, 8'd1);
        frame_op("R5 c22 read", 1'b0, 2'd0, PHY_ID, 5'd5, 16'h0, rv);
        chk("R5 read data", 64'(rv), 64'hA5C3);
        frame_op("R5 absent phy", 1'b0, 2'd0, 5'd9, 5'd2, 16'h0, rv);
        chk("R5 pull-up data", 64'(rv), 64'hFFFF);

        // R3 N=0 floor and an odd divider
        set_mode(1'b0, 8'd0);
        frame_op("R3 div0", 1'b0, 2'd1, PHY_ID, 5'd7, 16'h0F0F, rv);
        set_mode(1'b0, 8'd4);
        frame_op("R3 div5", 1'b0, 2'd0, PHY_ID, 5'd7, 16'h0, rv);
        chk("R3 R5 read div5", 64'(rv), 64'h0F0F);

        // Random Clause 22 write/read pairs
        for (int it = 0; it < 8; it++) begin
            logic [4:0] rg;
            rg = 5'($urandom_range(0, 31));
            v  = 16'($urandom);
            set_mode(1'b0, 8'($urandom_range(0, 6)));
            frame_op("R4 random write", 1'b0, 2'd1, PHY_ID, rg, v, rv);
            frame_op("R5 random read", 1'b0, 2'd0, PHY_ID, rg, 16'h0, rv);
            chk("R5 random data", 64'(rv), 64'(v));
        end

        // R6 R7 Clause 45 address, write, read
        set_mode(1'b1, 8'd2);
        frame_op("R6 c45 address", 1'b1, 2'd0, PHY_ID, 5'd1, 16'h0009, rv);
        frame_op("R7 c45 write", 1'b1, 2'd1, PHY_ID, 5'd1, 16'hBEEF, rv);
        frame_op("R7 c45 read", 1'b1, 2'd2, PHY_ID, 5'd1, 16'h0, rv);
        chk("R7 c45 read data", 64'(rv), 64'hBEEF);
        chk("R7 c45 stored", 64'(c45mem[9]), 64'hBEEF);

        // R10 invalid codes and missing start bit
        f0 = frames;
        bus_write(A_CMD, 32'h103);
        bus_read(A_CMD, r); chk("R10 c45 code3 not busy", 64'(r[16]), 64'd0);
        set_mode(1'b0, 8'd2);
        bus_write(A_CMD, 32'h102);
        bus_read(A_CMD, r); chk("R10 c22 code2 not busy", 64'(r[16]), 64'd0);
        bus_write(A_CMD, 32'h001);
        bus_read(A_CMD, r); chk("R10 no start bit", 64'(r[16]), 64'd0);
        f0 = rises;
        repeat (300) @(negedge clk);
        chk("R10 no MDC activity", 64'(rises - f0), 64'd0);

        // R9 start during busy is ignored
        bus_write(A_ADDR, {19'd0, PHY_ID, 3'd0, 5'd12});
        bus_write(A_WDATA, 32'h5A5A);
        f0 = frames;
        bus_write(A_CMD, 32'h101);
        repeat (20) @(negedge clk);
        bus_write(A_ADDR, {19'd0, 5'd4, 3'd0, 5'd1});
        bus_write(A_CMD, 32'h100);
        bus_addr = A_CMD; #1;
        cyc = 0;
        while (bus_rdata[16] && cyc < 20000) begin cyc++; @(negedge clk); #1; end
        chk("R9 frame unchanged", last_frame, exp_frame(1'b0, 2'd1, PHY_ID, 5'd12, 16'h5A5A));
        bus_read(A_CMD, r); chk("R9 code kept", 64'(r[1:0]), 64'd1);
        repeat (400) @(negedge clk);
        chk("R9 single frame", 64'(frames - f0), 64'd1);

        // R12 and R5 line-level monitors
        chk("R12 no change while MDC high", 64'(change_high), 64'd0);
        chk("R5 no line contention", 64'(contention), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule